// File: doc/BRIEF.md
# Circular Descriptor Ring Sample DMA

This block is a bus-master channel that streams audio samples from memory into a sample FIFO. It is steered by a ring of 32 descriptors in memory. Each descriptor is two dwords: the first holds the buffer address, and the second holds the sample count and an interrupt-request flag. Software builds the ring and writes the ring base address and a last-valid index, then sets a run bit. The engine fetches the descriptor at its current index and reads the buffer. It unpacks the buffer into samples, then steps the current index and fetches the next descriptor.

Once the entry at the last-valid index has been finished, the engine raises an end flag and makes no further memory reads. Software extends the ring by moving the last-valid index forward, and the engine then continues from where it stopped. Samples are either two 16-bit samples per dword or one 20-bit sample per dword. A pause bit, the run bit cleared, freezes the engine at once without losing its place.

Top module: `ring_dma_engine`

## Requirements
- R1: After reset the registers at offsets 0 (ring base), 1 (last-valid index), 2 (control) and 3 (status) all read 0. `irq`, `mem_req` and `fifo_push` are low.
- R2: For entry i the engine reads dword 0 at base+8*i and then dword 1 at base+8*i+4. In dword 1, bits [15:0] give the sample count and bit 31 requests an interrupt. `mem_addr` holds steady while a request waits for `mem_ack`.
- R3: In narrow mode (control bit 1 = 0), each buffer dword holds two samples, bits [15:0] first and then bits [31:16]. Each sample appears on `fifo_data[19:4]` with bits [3:0] at zero. With an odd count, only the low half of the last dword is used.
- R4: In wide mode (control bit 1 = 1), each buffer dword holds one sample, taken from bits [19:0].
- R5: Buffer dwords are read at consecutive addresses, starting at the address held in descriptor dword 0.
- R6: `irq` (and status bit 9) rises after the last sample of a buffer whose descriptor has bit 31 set. A buffer with bit 31 clear raises nothing.
- R7: Writing status with bit 9 set clears `irq`. If a completion that requests an interrupt lands in the same cycle, `irq` stays set.
- R8: When the entry at the last-valid index completes, status bit 8 (end) sets and status bits [4:0] show that index plus one. From then on, `mem_req` stays low.
- R9: Writing a last-valid index other than current index minus one clears the end flag. The engine then resumes fetching at the current index.
- R10: A descriptor with a sample count of 0 causes no buffer read. The index still advances, and its interrupt request is still honoured.
- R11: Clearing control bit 0 (run) stops `mem_req` and `fifo_push` from the next cycle and keeps the engine's position. Setting run again continues with no sample lost or repeated.
- R12: No sample is pushed while `fifo_full` is high, and back-pressure loses no samples.
- R13: The index wraps from 31 to 0, and entry 0 is fetched again at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_ack | input | 1 | Read accepted, data valid this cycle |
| mem_rdata | input | 32 | Memory read data |
| fifo_push | output | 1 | Sample write strobe |
| fifo_data | output | SAMPLE_W | Sample value |
| fifo_full | input | 1 | FIFO cannot take a sample |
| irq | output | 1 | Completion interrupt |

## Verification
Two events can land in the same cycle: the completion step of a buffer that requests an interrupt, and a software write that clears the interrupt. The bench provokes this by watching the FIFO port for the final sample of such a buffer. It then issues the clear write in the very next cycle, which is the cycle in which the completion is recorded. It judges the outcome by `irq` and status bit 9, which must still read 1 after the write. A second, isolated clear must then bring them to 0.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DESC0,
    ST_DESC1,
    ST_READ,
    ST_PUSH,
    ST_DONE
  } walk_st_e;

  localparam logic [1:0] RA_BASE = 2'd0;
  localparam logic [1:0] RA_LAST = 2'd1;
  localparam logic [1:0] RA_CTRL = 2'd2;
  localparam logic [1:0] RA_STAT = 2'd3;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_WIDE = 1;
  localparam int STAT_END  = 8;
  localparam int STAT_IRQ  = 9;
endpackage

// File: rtl/ring_dma_rst_sync.sv
module ring_dma_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic              end_flag,
  input  logic              done_ioc,
  output logic [ADDR_W-1:0] base_q,
  output logic [IDX_W-1:0]  lvi_q,
  output logic [IDX_W-1:0]  lvi_nxt,
  output logic              lvi_wr,
  output logic              run,
  output logic              wide,
  output logic              irq
);
  localparam int ALIGN_W = 3;

  logic              wr_base, wr_ctrl, wr_stat;
  logic [ADDR_W-1:0] base_n;
  logic              run_n, wide_n, irq_n;

  always_comb begin
    wr_base = reg_we && (reg_addr == RA_BASE);
    lvi_wr  = reg_we && (reg_addr == RA_LAST);
    wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    wr_stat = reg_we && (reg_addr == RA_STAT);
    base_n  = {reg_wdata[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
    lvi_nxt = lvi_wr ? reg_wdata[IDX_W-1:0] : lvi_q;
    run_n   = reg_wdata[CTRL_RUN];
    wide_n  = reg_wdata[CTRL_WIDE];
    irq_n   = done_ioc | (irq & ~(wr_stat & reg_wdata[STAT_IRQ]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      lvi_q  <= '0;
      run    <= 1'b0;
      wide   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr_base) base_q <= base_n;
      if (lvi_wr)  lvi_q  <= lvi_nxt;
      if (wr_ctrl) begin
        run  <= run_n;
        wide <= wide_n;
      end
      irq <= irq_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_BASE: reg_rdata = 32'(base_q);
      RA_LAST: reg_rdata[IDX_W-1:0] = lvi_q;
      RA_CTRL: begin
        reg_rdata[CTRL_RUN]  = run;
        reg_rdata[CTRL_WIDE] = wide;
      end
      default: begin
        reg_rdata[IDX_W-1:0] = cur_idx;
        reg_rdata[STAT_END]  = end_flag;
        reg_rdata[STAT_IRQ]  = irq;
      end
    endcase
  end

  // R7
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ioc |=> irq);

  // R6
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(done_ioc));
endmodule

// File: rtl/ring_dma_walker.sv
module ring_dma_walker
  import ring_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wide,
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  lvi_nxt,
  input  logic              lvi_wr,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              fifo_full,
  output logic              push,
  output logic [31:0]       hold_word,
  output logic              half_sel,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              end_flag,
  output logic              done_ioc
);
  localparam int DESC_SHIFT = 3;
  localparam int IOC_BIT    = 31;

  walk_st_e          st_q, st_n;
  logic [IDX_W-1:0]  idx_n, idx_prev;
  logic              end_n;
  logic [ADDR_W-1:0] badr_q, badr_n, desc_addr;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic              ioc_q, ioc_n;
  logic [31:0]       hold_n;
  logic              half_n;
  logic              last_smp;

  always_comb begin
    desc_addr = base + (ADDR_W'(cur_idx) << DESC_SHIFT);
    idx_prev  = cur_idx - 1'b1;
    last_smp  = (rem_q == LEN_W'(1));
    mem_req   = run && ((st_q == ST_DESC0) || (st_q == ST_DESC1) || (st_q == ST_READ));
    push      = run && (st_q == ST_PUSH) && !fifo_full;
    unique case (st_q)
      ST_DESC0: mem_addr = desc_addr;
      ST_DESC1: mem_addr = desc_addr + ADDR_W'(4);
      ST_READ:  mem_addr = badr_q;
      default:  mem_addr = desc_addr;
    endcase
  end

  always_comb begin
    st_n     = st_q;
    idx_n    = cur_idx;
    end_n    = end_flag;
    badr_n   = badr_q;
    rem_n    = rem_q;
    ioc_n    = ioc_q;
    hold_n   = hold_word;
    half_n   = half_sel;
    done_ioc = 1'b0;
    if (lvi_wr) end_n = end_flag && (lvi_nxt == idx_prev);
    if (run) begin
      unique case (st_q)
        ST_IDLE: if (!end_flag) st_n = ST_DESC0;
        ST_DESC0: if (mem_ack) begin
          badr_n = {mem_rdata[ADDR_W-1:2], 2'b00};
          st_n   = ST_DESC1;
        end
        ST_DESC1: if (mem_ack) begin
          ioc_n = mem_rdata[IOC_BIT];
          rem_n = mem_rdata[LEN_W-1:0];
          st_n  = (mem_rdata[LEN_W-1:0] == '0) ? ST_DONE : ST_READ;
        end
        ST_READ: if (mem_ack) begin
          hold_n = mem_rdata;
          badr_n = badr_q + ADDR_W'(4);
          half_n = 1'b0;
          st_n   = ST_PUSH;
        end
        ST_PUSH: if (push) begin
          rem_n = rem_q - 1'b1;
          if (last_smp)              st_n = ST_DONE;
          else if (wide || half_sel) st_n = ST_READ;
          else                       half_n = 1'b1;
        end
        ST_DONE: begin
          idx_n    = cur_idx + 1'b1;
          end_n    = (cur_idx == lvi_nxt);
          done_ioc = ioc_q;
          st_n     = ST_IDLE;
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      cur_idx   <= '0;
      end_flag  <= 1'b0;
      badr_q    <= '0;
      rem_q     <= '0;
      ioc_q     <= 1'b0;
      hold_word <= '0;
      half_sel  <= 1'b0;
    end else begin
      st_q      <= st_n;
      cur_idx   <= idx_n;
      end_flag  <= end_n;
      badr_q    <= badr_n;
      rem_q     <= rem_n;
      ioc_q     <= ioc_n;
      hold_word <= hold_n;
      half_sel  <= half_n;
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> !mem_req || $stable(mem_addr));

  // R8
  end_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_flag && !lvi_wr |=> !mem_req);

  // R11
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cur_idx) && $stable(rem_q) && $stable(badr_q));

  // R13
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cur_idx) |-> cur_idx == IDX_W'($past(cur_idx) + 1'b1));
endmodule

// File: rtl/ring_dma_pack.sv
module ring_dma_pack #(
  parameter int SAMPLE_W = 20,
  parameter int NARROW_W = 16
) (
  input  logic [2*NARROW_W-1:0] hold_word,
  input  logic                  half_sel,
  input  logic                  wide,
  output logic [SAMPLE_W-1:0]   sample
);
  logic [NARROW_W-1:0] half_w;
  logic [SAMPLE_W-1:0] narrow_s;

  assign half_w = half_sel ? hold_word[2*NARROW_W-1:NARROW_W] : hold_word[NARROW_W-1:0];

  generate
    if (SAMPLE_W > NARROW_W) begin : g_pad
      assign narrow_s = {half_w, {(SAMPLE_W-NARROW_W){1'b0}}};
    end else begin : g_trunc
      assign narrow_s = half_w[NARROW_W-1 -: SAMPLE_W];
    end
  endgenerate

  assign sample = wide ? hold_word[SAMPLE_W-1:0] : narrow_s;
endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine #(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 5,
  parameter int LEN_W    = 16,
  parameter int SAMPLE_W = 20,
  parameter int NARROW_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [1:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_ack,
  input  logic [31:0]         mem_rdata,
  output logic                fifo_push,
  output logic [SAMPLE_W-1:0] fifo_data,
  input  logic                fifo_full,
  output logic                irq
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] base_q;
  logic [IDX_W-1:0]  lvi_q, lvi_nxt, cur_idx;
  logic              lvi_wr, run, wide, end_flag, done_ioc, half_sel;
  logic [31:0]       hold_word;

  ring_dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ring_dma_regs #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .cur_idx   (cur_idx),
    .end_flag  (end_flag),
    .done_ioc  (done_ioc),
    .base_q    (base_q),
    .lvi_q     (lvi_q),
    .lvi_nxt   (lvi_nxt),
    .lvi_wr    (lvi_wr),
    .run       (run),
    .wide      (wide),
    .irq       (irq)
  );

  ring_dma_walker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .run       (run),
    .wide      (wide),
    .base      (base_q),
    .lvi_nxt   (lvi_nxt),
    .lvi_wr    (lvi_wr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .fifo_full (fifo_full),
    .push      (fifo_push),
    .hold_word (hold_word),
    .half_sel  (half_sel),
    .cur_idx   (cur_idx),
    .end_flag  (end_flag),
    .done_ioc  (done_ioc)
  );

  ring_dma_pack #(.SAMPLE_W(SAMPLE_W), .NARROW_W(NARROW_W)) u_pack (
    .hold_word (hold_word),
    .half_sel  (half_sel),
    .wide      (wide),
    .sample    (fifo_data)
  );

  // R12
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    fifo_full |-> !fifo_push);

  // R11
  paused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(reg_rdata[0]) && (reg_addr == 2'd2) |-> !mem_req && !fifo_push);
endmodule

// File: tb/sim_ring_dma_engine.sv
`timescale 1ns/1ps
module sim_ring_dma_engine;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;
  logic        fifo_push, fifo_full;
  logic [19:0] fifo_data;
  logic        irq;

  always #2 clk = ~clk;

  logic [31:0] dmem [0:1023];
  logic [15:0] lfsr;
  logic        full_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  assign mem_ack   = mem_req & lfsr[0];
  assign mem_rdata = dmem[mem_addr[11:2]];
  assign fifo_full = full_en & lfsr[3] & lfsr[5];

  ring_dma_engine u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_data(fifo_data), .fifo_full(fifo_full), .irq(irq)
  );

  typedef struct packed {
    logic [19:0] d;
    logic        last;
  } smp_t;

  smp_t        exp_q[$];
  logic [31:0] addr_q[$];
  int          checks = 0;
  int          fails = 0;
  int          pops = 0;
  logic        coll_ev = 1'b0;
  logic [31:0] nxt_buf = 32'h400;
  localparam logic [31:0] BASE = 32'h100;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: memory reads and FIFO pushes against the scoreboard queues
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (addr_q.size() == 0) chk(1'b0, "R2/R5 unexpected read", mem_addr, 32'hFFFFFFFF);
      else begin
        logic [31:0] ea;
        ea = addr_q.pop_front();
        chk(mem_addr == ea, "R2/R5 read address", mem_addr, ea);
      end
    end
    if (rst_n && fifo_push) begin
      chk(!fifo_full, "R12 push while full", {31'b0, fifo_full}, 32'h0);
      if (exp_q.size() == 0) chk(1'b0, "R3/R4 unexpected sample", {12'b0, fifo_data}, 32'hFFFFFFFF);
      else begin
        smp_t e;
        e = exp_q.pop_front();
        pops++;
        chk(fifo_data == e.d, "R3/R4 sample value", {12'b0, fifo_data}, {12'b0, e.d});
        if (e.last) coll_ev = 1'b1;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    v = reg_rdata;
  endtask

  // Driver: writes a descriptor and pushes the expected reads and samples
  task automatic add_desc(input int idx, input int len, input bit ioc, input bit wmode, input bit mark);
    int ndw;
    logic [31:0] w;
    ndw = wmode ? len : (len + 1) / 2;
    dmem[(BASE >> 2) + idx*2]     = nxt_buf;
    dmem[(BASE >> 2) + idx*2 + 1] = {ioc, 15'b0, 16'(len)};
    addr_q.push_back(BASE + 32'(idx*8));
    addr_q.push_back(BASE + 32'(idx*8 + 4));
    for (int k = 0; k < ndw; k++) addr_q.push_back(nxt_buf + 32'(4*k));
    for (int k = 0; k < len; k++) begin
      smp_t s;
      w = dmem[(nxt_buf >> 2) + (wmode ? k : k/2)];
      s.d = wmode ? w[19:0] : {((k % 2) != 0 ? w[31:16] : w[15:0]), 4'h0};
      s.last = mark && (k == len - 1);
      exp_q.push_back(s);
    end
    nxt_buf = nxt_buf + 32'(4*ndw) + 32'h10;
  endtask

  task automatic wait_end();
    logic [31:0] v;
    for (int n = 0; n < 20000; n++) begin
      rd(2'd3, v);
      if (v[8]) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    summary();
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) dmem[i] = (32'(i) * 32'h9E3779B1) ^ 32'h5A5A3C3C;
    full_en = 1'b0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd3; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk(v == 0, "R1 base reset", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 last-valid reset", v, 0);
    rd(2'd2, v); chk(v == 0, "R1 control reset", v, 0);
    rd(2'd3, v); chk(v == 0, "R1 status reset", v, 0);
    chk({irq, mem_req, fifo_push} == 3'b000, "R1 outputs idle", {29'b0, irq, mem_req, fifo_push}, 0);

    // Single narrow odd-length entry, no interrupt request (R3, R6, R8)
    add_desc(0, 5, 1'b0, 1'b0, 1'b0);
    wr(2'd0, BASE);
    wr(2'd1, 32'd0);
    wr(2'd2, 32'h1);
    wait_end();
    rd(2'd3, v);
    chk(v[4:0] == 5'd1 && v[8], "R8 end flag and index", v, 32'h101);
    chk(!irq && !v[9], "R6 no irq without request", {31'b0, irq}, 0);
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R3 all samples delivered", 32'(exp_q.size()), 0);
    for (int n = 0; n < 20; n++) begin
      @(negedge clk);
      if (mem_req) begin chk(1'b0, "R8 read after end", 1, 0); break; end
    end
    chk(1'b1, "R8 quiet after end", 0, 0);

    // Extend the ring: zero-length and interrupt-requesting entries (R9, R10, R6)
    add_desc(1, 0, 1'b1, 1'b0, 1'b0);
    add_desc(2, 4, 1'b0, 1'b0, 1'b0);
    add_desc(3, 3, 1'b1, 1'b0, 1'b0);
    wr(2'd1, 32'd3);
    rd(2'd3, v);
    chk(!v[8], "R9 end cleared by index move", v, 0);
    wait_end();
    rd(2'd3, v);
    chk(v[4:0] == 5'd4, "R9 resumed to index 4", v, 4);
    chk(irq && v[9], "R6 irq after requesting buffer", {31'b0, irq}, 1);
    chk(addr_q.size() == 0 && exp_q.size() == 0, "R10 no buffer read for zero length", 32'(addr_q.size()), 0);

    // R7 clear
    wr(2'd3, 32'h200);
    chk(!irq, "R7 irq cleared", {31'b0, irq}, 0);

    // R4 wide mode
    wr(2'd2, 32'h3);
    add_desc(4, 3, 1'b0, 1'b1, 1'b0);
    wr(2'd1, 32'd4);
    wait_end();
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R4 wide samples delivered", 32'(exp_q.size()), 0);

    // R11 pause with R12 back-pressure
    full_en = 1'b1;
    add_desc(5, 24, 1'b0, 1'b1, 1'b0);
    wr(2'd1, 32'd5);
    wait (pops >= 18);
    wr(2'd2, 32'h2);
    for (int n = 0; n < 12; n++) begin
      if (mem_req || fifo_push) begin chk(1'b0, "R11 activity while paused", 1, 0); break; end
      @(negedge clk);
    end
    chk(1'b1, "R11 paused", 0, 0);
    rd(2'd3, v);
    chk(v[4:0] == 5'd5 && !v[8], "R11 position kept", v, 5);
    wr(2'd2, 32'h3);
    wait_end();
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R11 R12 no loss after resume", 32'(exp_q.size()), 0);
    full_en = 1'b0;

    // R13 wrap and R7 same-cycle collision
    wr(2'd2, 32'h1);
    for (int i = 6; i < 31; i++) add_desc(i, 0, 1'b0, 1'b0, 1'b0);
    add_desc(31, 2, 1'b1, 1'b0, 1'b1);
    add_desc(0, 2, 1'b0, 1'b0, 1'b0);
    wr(2'd1, 32'd0);
    @(posedge coll_ev);
    wr(2'd3, 32'h200);
    rd(2'd3, v);
    chk(irq && v[9], "R7 set wins over clear", {31'b0, irq}, 1);
    wait_end();
    rd(2'd3, v);
    chk(v[4:0] == 5'd1 && v[8], "R13 wrap to index 1", v, 32'h101);
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R13 entry 0 refetched at base", 32'(addr_q.size()), 0);
    wr(2'd3, 32'h200);
    chk(!irq, "R7 second clear", {31'b0, irq}, 0);

    summary();
  end
endmodule